// File: doc/BRIEF.md
# Delay Memory Access Unit

This unit carries out the delay-line instructions of a sample-oriented audio DSP. It works against its own circular sample store. Each cycle it may accept one decoded 32-bit instruction word together with the current accumulator and the address-pointer register. One clock later it returns three values: the new accumulator, the accumulator value the instruction started from, and a last-read sample register. That register holds the most recent sample fetched from memory.

Four operations are supported:

- a read-and-accumulate at an address taken from the instruction;
- the same read using an address taken from the upper bits of the 24-bit pointer;
- a write that stores the accumulator and then scales it;
- a write that stores the accumulator and then scales it and adds the last-read sample.

The write with last-read add lets a program fold a fetched sample back into a scaled accumulator in one step, which suits all-pass and comb structures. A full store holds 32768 samples. The address width is a parameter so that a small instance can be simulated. Addresses are reduced modulo the store depth.

Top module: `dly_mem_unit`

## Requirements
- R1: The operation is selected by `ins_word[4:0]`: 0 is direct read-accumulate, 1 is pointer read-accumulate, 2 is write-and-scale, and 3 is write-scale-add-last-read. Any other value produces no result, writes nothing and leaves every output register unchanged.
- R2: The coefficient is `ins_word[31:21]`, a two's-complement value with 9 fraction bits (range -2.0 to +1.998). The direct address is `ins_word[19:5]`; only its low `ADDR_BITS` bits are used, so addresses that differ by a multiple of the depth alias.
- R3: Direct read gives `acc_out = sat(acc_in + floor(coef*mem[addr]/512))`, and `lr_out` becomes `mem[addr]`.
- R4: Pointer read uses `ptr_in[8 +: ADDR_BITS]` as the address. The low 8 pointer bits and the bits above the address are ignored. Otherwise it matches R3.
- R5: Write-and-scale stores `acc_in` into `mem[addr]` and gives `acc_out = sat(floor(coef*acc_in/512))`. `lr_out` is unchanged.
- R6: Write-scale-add-last-read stores `acc_in` into `mem[addr]` and gives `acc_out = sat(lr + floor(coef*acc_in/512))`. Here `lr` is the last-read value from before this instruction. `lr_out` is unchanged.
- R7: For every accepted instruction, `pacc_out` equals that instruction's `acc_in`.
- R8: All results saturate to 0x7FFFFF and 0x800000 instead of wrapping. Products round toward negative infinity.
- R9: Results appear with `res_valid` high exactly one cycle after the instruction. Instructions may be issued back to back, and a read sees a write made by the instruction before it.
- R10: While reset is held and after it, before any instruction, `res_valid` is low and `acc_out`, `pacc_out` and `lr_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_word | input | 32 | Decoded instruction word |
| acc_in | input | 24 | Current accumulator, signed fraction |
| ptr_in | input | 24 | Address-pointer register |
| res_valid | output | 1 | Result registers updated this cycle |
| acc_out | output | 24 | New accumulator |
| pacc_out | output | 24 | Accumulator before the instruction |
| lr_out | output | 24 | Last sample read from memory |

## Verification
The embedded assertions check the per-cycle rules on every clock:

- the one-cycle result timing;
- the capture of the previous accumulator;
- that the last-read register changes only on read operations;
- that a write lands in the store;
- the sign of scaled results.

The bench's scenarios are needed for the values themselves:

- the rounded and saturated products at both extremes;
- the fold-back of the last-read sample;
- pointer bit selection and address aliasing;
- the effect of an illegal opcode on stored data.

A behavioural model recomputes each of these from the requirements.

// File: rtl/dmu_pkg.sv
package dmu_pkg;
  localparam int SMP_W     = 24;
  localparam int COEF_W    = 11;
  localparam int COEF_FRAC = 9;
  localparam int PROD_W    = SMP_W + COEF_W;
  localparam int SCL_W     = PROD_W - COEF_FRAC;
  localparam int SUM_W     = SCL_W + 1;

  typedef enum logic [1:0] {
    OP_RD_DIR = 2'd0,
    OP_RD_PTR = 2'd1,
    OP_WR_SCL = 2'd2,
    OP_WR_ADD = 2'd3
  } dmu_op_e;

  // base + floor(coef * x / 2^COEF_FRAC), saturated to SMP_W bits
  function automatic logic [SMP_W-1:0] scale_add(input logic [SMP_W-1:0] base,
                                                 input logic [COEF_W-1:0] coef,
                                                 input logic [SMP_W-1:0] x);
    logic [PROD_W-1:0] prod;
    logic [SUM_W-1:0]  sum;
    prod = {{SMP_W{coef[COEF_W-1]}}, coef} * {{COEF_W{x[SMP_W-1]}}, x};
    sum  = {{(SUM_W-SMP_W){base[SMP_W-1]}}, base}
         + {prod[PROD_W-1], prod[PROD_W-1:COEF_FRAC]};
    if (sum[SUM_W-1:SMP_W-1] == '0 || sum[SUM_W-1:SMP_W-1] == '1)
      return sum[SMP_W-1:0];
    else if (sum[SUM_W-1])
      return {1'b1, {(SMP_W-1){1'b0}}};
    else
      return {1'b0, {(SMP_W-1){1'b1}}};
  endfunction
endpackage

// File: rtl/dmu_decode.sv
module dmu_decode
  import dmu_pkg::*;
(
  input  logic [31:0]       word,
  output dmu_op_e           op,
  output logic              legal,
  output logic              is_read,
  output logic              is_write,
  output logic [COEF_W-1:0] coef,
  output logic [14:0]       dir_addr
);
  logic unused_bit;
  assign unused_bit = word[20];

  assign op       = dmu_op_e'(word[1:0]);
  assign legal    = (word[4:2] == 3'b000);
  assign is_read  = legal && !word[1];
  assign is_write = legal && word[1];
  assign coef     = word[31:21];
  assign dir_addr = word[19:5];
endmodule

// File: rtl/dmu_sample_ram.sv
module dmu_sample_ram
  import dmu_pkg::*;
#(
  parameter int ADDR_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_BITS-1:0] waddr,
  input  logic [SMP_W-1:0]     wdata,
  input  logic [ADDR_BITS-1:0] raddr,
  output logic [SMP_W-1:0]     rdata
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [SMP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R9
  ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/dmu_alu.sv
module dmu_alu
  import dmu_pkg::*;
(
  input  dmu_op_e           op,
  input  logic [COEF_W-1:0] coef,
  input  logic [SMP_W-1:0]  acc,
  input  logic [SMP_W-1:0]  sample,
  input  logic [SMP_W-1:0]  lr,
  output logic [SMP_W-1:0]  result
);
  always_comb begin
    unique case (op)
      OP_RD_DIR, OP_RD_PTR: result = scale_add(acc, coef, sample);
      OP_WR_SCL:            result = scale_add('0, coef, acc);
      OP_WR_ADD:            result = scale_add(lr, coef, acc);
      default:              result = '0;
    endcase
  end
endmodule

// File: rtl/dly_mem_unit.sv
module dly_mem_unit
  import dmu_pkg::*;
#(
  parameter int ADDR_BITS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ins_valid,
  input  logic [31:0] ins_word,
  input  logic [23:0] acc_in,
  input  logic [23:0] ptr_in,
  output logic        res_valid,
  output logic [23:0] acc_out,
  output logic [23:0] pacc_out,
  output logic [23:0] lr_out
);
  dmu_op_e           op;
  logic              legal, is_read, is_write;
  logic [COEF_W-1:0] coef;
  logic [14:0]       dir_addr;
  logic [ADDR_BITS-1:0] rd_addr, wr_addr;
  logic [SMP_W-1:0]  rd_sample, alu_res;
  logic              accept, rd_fire, wr_fire;
  logic              unused_addr_bits;

  logic              res_valid_q;
  logic [SMP_W-1:0]  acc_q, pacc_q, lr_q;

  dmu_decode u_dec (
    .word(ins_word), .op(op), .legal(legal), .is_read(is_read),
    .is_write(is_write), .coef(coef), .dir_addr(dir_addr)
  );

  assign unused_addr_bits = ^{ptr_in, dir_addr};
  assign wr_addr = dir_addr[ADDR_BITS-1:0];
  assign rd_addr = (op == OP_RD_PTR) ? ptr_in[8 +: ADDR_BITS] : dir_addr[ADDR_BITS-1:0];

  assign accept  = ins_valid && legal;
  assign rd_fire = ins_valid && is_read;
  assign wr_fire = ins_valid && is_write;

  dmu_sample_ram #(.ADDR_BITS(ADDR_BITS)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .waddr(wr_addr), .wdata(acc_in),
    .raddr(rd_addr), .rdata(rd_sample)
  );

  dmu_alu u_alu (
    .op(op), .coef(coef), .acc(acc_in), .sample(rd_sample), .lr(lr_q),
    .result(alu_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      acc_q       <= '0;
      pacc_q      <= '0;
      lr_q        <= '0;
    end else begin
      res_valid_q <= accept;
      if (accept) begin
        acc_q  <= alu_res;
        pacc_q <= acc_in;
      end
      if (rd_fire) lr_q <= rd_sample;
    end
  end

  assign res_valid = res_valid_q;
  assign acc_out   = acc_q;
  assign pacc_out  = pacc_q;
  assign lr_out    = lr_q;

  // R9
  valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);
  // R1
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (!res_valid && $stable(acc_out) && $stable(pacc_out)));
  // R7
  pacc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pacc_out == $past(acc_in)));
  // R3
  lr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (lr_out == $past(rd_sample)));
  // R5
  lr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(lr_out));
  // R8
  scale_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && op == OP_WR_SCL && !coef[COEF_W-1] && !acc_in[SMP_W-1]) |=> !acc_out[SMP_W-1]);
endmodule

// File: tb/tb_dly_mem_unit.sv
module tb_dly_mem_unit;
  localparam int AB = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, ins_valid, res_valid;
  logic [31:0] ins_word;
  logic [23:0] acc_in, ptr_in, acc_out, pacc_out, lr_out;

  dly_mem_unit #(.ADDR_BITS(AB)) dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
    .acc_in(acc_in), .ptr_in(ptr_in), .res_valid(res_valid), .acc_out(acc_out),
    .pacc_out(pacc_out), .lr_out(lr_out)
  );

  typedef struct {
    logic [23:0] acc;
    logic [23:0] pacc;
    logic [23:0] lr;
    int          req;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          errors = 0;
  logic [23:0] ref_mem [1 << AB];
  logic [23:0] ref_lr = '0;

  // floor division by 512 written with integer arithmetic, then clamping
  function automatic logic [23:0] ref_mac(logic [23:0] base, logic [10:0] coef, logic [23:0] x);
    longint b, c, v, p, q, s;
    b = longint'($signed(base));
    c = longint'($signed(coef));
    v = longint'($signed(x));
    p = c * v;
    if (p >= 0) q = p / 512;
    else        q = -((-p + 511) / 512);
    s = b + q;
    if (s > 8388607)  s = 8388607;
    if (s < -8388608) s = -8388608;
    return s[23:0];
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(int req, logic [4:0] op, logic [10:0] coef, logic [14:0] addr,
                       logic [23:0] acc, logic [23:0] ptr);
    exp_t e;
    logic [AB-1:0] ra, wa;
    @(negedge clk);
    ins_valid = 1'b1;
    ins_word  = {coef, 1'b0, addr, op};
    acc_in    = acc;
    ptr_in    = ptr;
    ra = (op == 5'd1) ? ptr[8 +: AB] : addr[AB-1:0];
    wa = addr[AB-1:0];
    e.pacc = acc;
    e.req  = req;
    e.acc  = '0;
    if (op <= 5'd3) begin
      case (op)
        5'd0, 5'd1: begin e.acc = ref_mac(acc, coef, ref_mem[ra]); ref_lr = ref_mem[ra]; end
        5'd2: begin e.acc = ref_mac(24'd0, coef, acc); ref_mem[wa] = acc; end
        default: begin e.acc = ref_mac(ref_lr, coef, acc); ref_mem[wa] = acc; end
      endcase
      e.lr = ref_lr;
      sb_q.push_back(e);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ins_valid = 1'b0;
    end
  endtask

  // monitor: pop and compare each produced result
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected result actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check($sformatf("R%0d acc", e.req),  acc_out,  e.acc);
        check($sformatf("R7 pacc (R%0d)", e.req), pacc_out, e.pacc);
        check($sformatf("R%0d lr", e.req),   lr_out,   e.lr);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] held;
    rst_n = 1'b0; ins_valid = 1'b0; ins_word = '0; acc_in = '0; ptr_in = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", {23'd0, res_valid}, 24'd0);
    check("R10 acc", acc_out, 24'd0);
    check("R10 pacc", pacc_out, 24'd0);
    check("R10 lr", lr_out, 24'd0);
    rst_n = 1'b1;
    idle(1);
    check("R10 lr after release", lr_out, 24'd0);

    // R5 fill addresses 0..15 with write-and-scale, coefficient 1.0
    for (int i = 0; i < 16; i++)
      issue(5, 5'd2, 11'h200, 15'(i), 24'(32'h0A1234 * (i + 1)), 24'd0);
    // R5 half scale and negative scale
    issue(5, 5'd2, 11'h100, 15'd20, 24'h123456, 24'd0);
    issue(5, 5'd2, 11'h600, 15'd21, 24'h0F0F0F, 24'd0);
    idle(2);

    // R3 direct reads accumulate, various coefficients
    issue(3, 5'd0, 11'h200, 15'd3, 24'h000100, 24'd0);
    issue(3, 5'd0, 11'h7FF, 15'd20, 24'hFFF000, 24'd0);
    issue(3, 5'd0, 11'h0C3, 15'd7, 24'h400000, 24'd0);
    // R2 alias: address 3 + depth reads address 3
    issue(2, 5'd0, 11'h200, 15'(3 + (1 << AB)), 24'd0, 24'd0);
    // R4 pointer reads with junk low bits and high bits
    issue(4, 5'd1, 11'h200, 15'd0, 24'd0, 24'h0005AB);
    issue(4, 5'd1, 11'h155, 15'd0, 24'h010000, {6'h3F, 10'd9, 8'h7E});
    // R6 fold-back of last-read (from address 9)
    issue(6, 5'd3, 11'h180, 15'd30, 24'h200000, 24'd0);
    issue(6, 5'd3, 11'h700, 15'd31, 24'hC00000, 24'd0);
    idle(2);

    // R8 saturation at both extremes
    issue(8, 5'd2, 11'h200, 15'd40, 24'h7FFFFF, 24'd0);
    issue(8, 5'd2, 11'h200, 15'd41, 24'h800000, 24'd0);
    issue(8, 5'd0, 11'h3FF, 15'd40, 24'h7FFFFF, 24'd0);
    issue(8, 5'd0, 11'h3FF, 15'd41, 24'h800000, 24'd0);
    issue(8, 5'd2, 11'h400, 15'd42, 24'h800000, 24'd0);
    issue(8, 5'd3, 11'h3FF, 15'd43, 24'h800000, 24'd0);
    issue(8, 5'd2, 11'h400, 15'd44, 24'h000001, 24'd0);
    idle(2);

    // R9 back-to-back write then read of the same address
    issue(9, 5'd2, 11'h200, 15'd50, 24'h3C3C3C, 24'd0);
    issue(9, 5'd0, 11'h200, 15'd50, 24'd0, 24'd0);
    issue(9, 5'd1, 11'h200, 15'd0, 24'h000010, {8'd0, 8'd50, 8'h00});
    idle(2);

    // R1 illegal opcode: no result, no write, outputs held
    held = acc_out;
    issue(1, 5'd4, 11'h200, 15'd3, 24'h555555, 24'd0);
    issue(1, 5'd18, 11'h200, 15'd3, 24'h666666, 24'd0);
    idle(1);
    check("R1 acc held", acc_out, held);
    check("R1 valid low", {23'd0, res_valid}, 24'd0);
    issue(1, 5'd0, 11'h200, 15'd3, 24'd0, 24'd0);
    idle(2);

    // mixed traffic over the filled addresses
    for (int i = 0; i < 60; i++) begin
      logic [14:0] a;
      a = 15'($urandom % 16);
      case ($urandom % 4)
        0: issue(3, 5'd0, 11'($urandom), a, 24'($urandom), 24'd0);
        1: issue(4, 5'd1, 11'($urandom), 15'd0, 24'($urandom),
                 {6'($urandom), 10'(a), 8'($urandom)});
        2: issue(5, 5'd2, 11'($urandom), a, 24'($urandom), 24'd0);
        default: issue(6, 5'd3, 11'($urandom), a, 24'($urandom), 24'd0);
      endcase
    end
    idle(4);

    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R9 pending results actual=%0d expected=0", sb_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule